// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands in a single combinational pass and returns their full-width signed product, with an optional register on the output. The multiplier operand is recoded in overlapping three-bit windows. Each window picks one row from zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. An eight-bit multiplier therefore produces four rows rather than eight.

Each row is sign-extended to the full product width and shifted left by two bit positions per window index. A negative row is formed by inverting the shifted multiple, and the missing +1 is fed into the carry input of that row's adder. The rows are summed by a chain of block carry-lookahead adders. Twice the multiplicand is a one-bit wiring shift, so no adder is needed for it. When the multiplier width is odd, its sign bit is repeated once so that the windows cover an even width.

A user drives both operands on one clock edge. With the default output register, the product appears on `prod_o` after the next rising edge.

Top module: `booth_mul`

## Requirements
- R1: For every pair of signed operands, `prod_o` equals their exact signed product, A_W+B_W bits wide.
- R2: Window recoding, bits written high to low with a zero appended below the multiplier LSB: 000 and 111 give 0; 001 and 010 give +M; 011 gives +2M; 100 gives -2M; 101 and 110 give -M. Window k covers multiplier bits 2k+1, 2k and 2k-1.
- R3: Multiplier values whose windows select ±2M, for example 2 and -2, give correct products.
- R4: With OUT_REG=1, `prod_o` changes only at a rising clock edge. It shows the product of the operands sampled at the previous edge, and it holds while the operands stay stable.
- R5: A synchronous active-high `rst` forces `prod_o` to zero at the next rising edge, whatever the operands are.
- R6: -128 × -128 gives +16384 (0x4000), and -128 × 127 gives -16256 (0xC080). Neither overflows into the sign bit.
- R7: 0x81 (-127) × 0x7E (126) gives 0xC17E (-16002).
- R8: A zero in either operand gives a zero product.
- R9: When both operands are non-zero, the product sign bit equals the XOR of the two operand sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mcand_i | input | A_W (8) | Signed multiplicand |
| mplier_i | input | B_W (8) | Signed multiplier, recoded in three-bit windows |
| prod_o | output | A_W+B_W (16) | Signed product |

## Verification
The bound checks assume the default registered output: each product is compared with the operands sampled one edge earlier. The checks are enabled only from the first edge after reset is released, so they never rely on operand values from before that edge. The checks also assume the operands are never unknown. The bench drives the operands only on falling edges, always to defined values, and samples `prod_o` on the following falling edge. In this way every operand pair, including both most-negative corner cases, is presented for exactly one full cycle.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Row selection produced by one recoding window
  typedef enum logic [2:0] {
    BS_ZERO = 3'd0,
    BS_P1   = 3'd1,
    BS_P2   = 3'd2,
    BS_N1   = 3'd3,
    BS_N2   = 3'd4
  } booth_sel_e;

  // Window value = -2*w[2] + w[1] + w[0]
  function automatic booth_sel_e booth_decode(input logic [2:0] w);
    booth_sel_e s;
    case (w)
      3'b001, 3'b010: s = BS_P1;
      3'b011:         s = BS_P2;
      3'b100:         s = BS_N2;
      3'b101, 3'b110: s = BS_N1;
      default:        s = BS_ZERO;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0]  win_i,
  output booth_sel_e  sel_o
);
  assign sel_o = booth_decode(win_i);
endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
  import booth_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int ROW_W = 16,
  parameter int SHIFT = 0
) (
  input  logic [A_W-1:0]   mcand_i,
  input  booth_sel_e       sel_i,
  output logic [ROW_W-1:0] row_o,
  output logic             neg_o
);
  localparam int EXT_W = ROW_W - A_W;

  logic [ROW_W-1:0] single_m;
  logic [ROW_W-1:0] double_m;
  logic [ROW_W-1:0] mag;
  logic [ROW_W-1:0] placed;

  assign single_m = {{EXT_W{mcand_i[A_W-1]}}, mcand_i};
  assign double_m = single_m << 1;

  always_comb begin
    case (sel_i)
      BS_P1, BS_N1: mag = single_m;
      BS_P2, BS_N2: mag = double_m;
      default:      mag = '0;
    endcase
  end

  // Shift first: ~(x<<s)+1 == -(x<<s); the +1 enters as adder carry-in
  assign placed = mag << SHIFT;
  assign neg_o  = (sel_i == BS_N1) || (sel_i == BS_N2);
  assign row_o  = neg_o ? ~placed : placed;
endmodule

// File: rtl/booth_cla.sv
module booth_cla #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  localparam int NG = (W + 3) / 4;
  localparam int WP = NG * 4;

  logic [WP-1:0] a_p, b_p, s_p;
  logic [WP-1:0] g, p;
  logic [NG:0]   gc;

  assign a_p   = WP'(a_i);
  assign b_p   = WP'(b_i);
  assign g     = a_p & b_p;
  assign p     = a_p ^ b_p;
  assign gc[0] = cin_i;

  for (genvar j = 0; j < NG; j++) begin : g_grp
    logic [3:0] gg, pp;
    logic [3:0] c;
    logic       grp_g, grp_p;
    assign gg = g[4*j +: 4];
    assign pp = p[4*j +: 4];
    assign c[0] = gc[j];
    assign c[1] = gg[0] | (pp[0] & c[0]);
    assign c[2] = gg[1] | (pp[1] & gg[0]) | (pp[1] & pp[0] & c[0]);
    assign c[3] = gg[2] | (pp[2] & gg[1]) | (pp[2] & pp[1] & gg[0])
                | (pp[2] & pp[1] & pp[0] & c[0]);
    assign grp_g = gg[3] | (pp[3] & gg[2]) | (pp[3] & pp[2] & gg[1])
                 | (pp[3] & pp[2] & pp[1] & gg[0]);
    assign grp_p = &pp;
    assign gc[j+1] = grp_g | (grp_p & c[0]);
    assign s_p[4*j +: 4] = pp ^ c;
  end

  assign sum_o = s_p[W-1:0];
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int A_W     = 8,
  parameter int B_W     = 8,
  parameter int OUT_REG = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [A_W-1:0]     mcand_i,
  input  logic [B_W-1:0]     mplier_i,
  output logic [A_W+B_W-1:0] prod_o
);
  localparam int P_W   = A_W + B_W;
  localparam int BE_W  = B_W + (B_W % 2);   // even multiplier width
  localparam int NROW  = BE_W / 2;
  localparam int ROW_W = A_W + BE_W;

  logic [BE_W:0]    mplier_ext;             // extra LSB zero appended
  logic [ROW_W-1:0] acc [0:NROW];
  logic [P_W-1:0]   prod_c;

  if (BE_W != B_W) begin : g_odd
    assign mplier_ext = {mplier_i[B_W-1], mplier_i, 1'b0};
  end else begin : g_even
    assign mplier_ext = {mplier_i, 1'b0};
  end

  assign acc[0] = '0;

  for (genvar k = 0; k < NROW; k++) begin : g_row
    booth_sel_e       sel;
    logic [ROW_W-1:0] row;
    logic             neg;

    booth_recoder u_rec (
      .win_i (mplier_ext[2*k+2 -: 3]),
      .sel_o (sel)
    );

    booth_row_gen #(.A_W(A_W), .ROW_W(ROW_W), .SHIFT(2*k)) u_row (
      .mcand_i (mcand_i),
      .sel_i   (sel),
      .row_o   (row),
      .neg_o   (neg)
    );

    booth_cla #(.W(ROW_W)) u_add (
      .a_i   (acc[k]),
      .b_i   (row),
      .cin_i (neg),
      .sum_o (acc[k+1])
    );
  end

  assign prod_c = acc[NROW][P_W-1:0];

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) prod_o <= '0;
      else     prod_o <= prod_c;
    end
  end else begin : g_comb
    assign prod_o = prod_c;
  end
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int A_W     = 8,
  parameter int B_W     = 8,
  parameter int OUT_REG = 1
) (
  input logic               clk,
  input logic               rst,
  input logic [A_W-1:0]     mcand_i,
  input logic [B_W-1:0]     mplier_i,
  input logic [A_W+B_W-1:0] prod_o
);
  localparam int P_W = A_W + B_W;

  logic           primed;
  logic           rst_d;
  logic [P_W-1:0] ref_p;

  assign ref_p = P_W'($signed({{B_W{mcand_i[A_W-1]}}, mcand_i})
                    * $signed({{A_W{mplier_i[B_W-1]}}, mplier_i}));

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  if (OUT_REG != 0) begin : g_chk
    always_ff @(posedge clk) begin
      rst_d <= rst;
      // R5
      if (rst_d) reset_clear_chk: assert (prod_o == '0);
    end

    // R1
    product_match_chk: assert property (@(posedge clk) disable iff (rst)
      primed |-> prod_o == $past(ref_p));

    // R8
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
      primed && ($past(mcand_i) == '0 || $past(mplier_i) == '0) |-> prod_o == '0);

    // R9
    sign_rule_chk: assert property (@(posedge clk) disable iff (rst)
      primed && $past(mcand_i) != '0 && $past(mplier_i) != '0
      |-> prod_o[P_W-1] == ($past(mcand_i[A_W-1]) ^ $past(mplier_i[B_W-1])));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      primed && $stable(mcand_i) && $stable(mplier_i) |=> $stable(prod_o));
  end else begin : g_nochk
    assign rst_d = 1'b0;
  end
endmodule

bind booth_mul booth_mul_chk #(.A_W(A_W), .B_W(B_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {multiplicand, multiplier, expected product}
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    {8'h81, 8'h7E, 16'hC17E},
    {8'h80, 8'h80, 16'h4000},
    {8'h80, 8'h7F, 16'hC080},
    {8'h7F, 8'h7F, 16'h3F01},
    {8'h03, 8'h01, 16'h0003},
    {8'h03, 8'h02, 16'h0006},
    {8'h05, 8'hFF, 16'hFFFB},
    {8'h00, 8'hB3, 16'h0000},
    {8'hFF, 8'hFF, 16'h0001},
    {8'h07, 8'h03, 16'h0015},
    {8'h0C, 8'hFE, 16'hFFE8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mcand_i = 8'h00;
  logic [7:0]  mplier_i = 8'h00;
  logic [15:0] prod_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mul #(.A_W(8), .B_W(8), .OUT_REG(1)) dut (
    .clk(clk), .rst(rst), .mcand_i(mcand_i), .mplier_i(mplier_i), .prod_o(prod_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, mcand_i, mplier_i, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] sa, sb;
    sa = 16'($signed(a));
    sb = 16'($signed(b));
    return 16'(sa * sb);
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    mcand_i = a;
    mplier_i = b;
    @(negedge clk);
  endtask

  initial begin
    // R5: reset holds output at zero with non-zero operands
    mcand_i = 8'h55; mplier_i = 8'h33;
    repeat (3) @(negedge clk);
    check("R5", prod_o, 16'h0000);
    rst = 1'b0;

    foreach (VEC[i]) begin
      apply(VEC[i][31:24], VEC[i][23:16]);
      check("R2", prod_o, VEC[i][15:0]);
    end

    // R7: stated vector
    apply(8'h81, 8'h7E);
    check("R7", prod_o, 16'hC17E);
    // R6: most-negative corners
    apply(8'h80, 8'h80);
    check("R6", prod_o, 16'h4000);
    apply(8'h80, 8'h7F);
    check("R6", prod_o, 16'hC080);
    // R3: +-2M windows
    apply(8'h09, 8'h02);
    check("R3", prod_o, 16'h0012);
    apply(8'hF7, 8'hFE);
    check("R3", prod_o, 16'h0012);

    // R4: new operands do not reach the output before the edge
    apply(8'h10, 8'h10);
    mcand_i = 8'h02; mplier_i = 8'h03;
    #1;
    check("R4", prod_o, 16'h0100);
    @(negedge clk);
    check("R4", prod_o, 16'h0006);
    @(negedge clk);
    check("R4", prod_o, 16'h0006);

    // R5: mid-run synchronous reset
    rst = 1'b1;
    @(negedge clk);
    check("R5", prod_o, 16'h0000);
    rst = 1'b0;

    // R1, R8, R9: every operand pair
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply(8'(a), 8'(b));
        if (a == 0 || b == 0) check("R8", prod_o, 16'h0000);
        else begin
          check("R1", prod_o, ref_mul(8'(a), 8'(b)));
          check("R9", {15'b0, prod_o[15]}, {15'b0, mcand_i[7] ^ mplier_i[7]});
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule